// File: doc/BRIEF.md
# Single-Input-Change Scan Pattern Generator

This block is a free-running built-in self-test stimulus source. It fills a set of parallel scan chains, each with a fixed number of cells, and drives a vector of primary inputs. A maximal-length LFSR holds a seed for each pattern. A Johnson counter supplies a base codeword.

During each shift cycle, a rotating copy of the codeword is combined by XOR with one seed bit per chain. The result gives one new scan-in bit for every chain. After the chains have been filled, the block spends one capture cycle with shift enable low and pulses a done strobe. It then moves to the next pattern: the Johnson counter takes one ordinary step and the LFSR advances one state.

Because the rotation is the same for every pattern, the words loaded into one chain by consecutive patterns differ only by the single bit that the Johnson step flipped. The seed bit of the chain can invert the whole word.

Top module: `msic_tpg`

## Requirements
- R1: While reset is held and in the first cycle after it, shift_en_o=1 and done_o=0. pi_o equals the SEED parameter, and scan_o[i] equals SEED[i mod LFSR_W], because the Johnson codeword resets to all zeros.
- R2: The seed register advances only once per pattern, on the capture cycle. Its next state is {s[LFSR_W-2:0], ^(s & TAPS)}, and pi_o shows the current seed for the whole pattern.
- R3: Each pattern is CHAIN_LEN cycles with shift_en_o=1 and done_o=0, followed by one capture cycle with shift_en_o=0 and done_o=1. The period is CHAIN_LEN+1 cycles.
- R4: In shift cycle k (counted from 0 within the pattern), scan_o[i] = W[((i mod CHAIN_LEN) - k) mod CHAIN_LEN] ^ seed[i mod LFSR_W], where W is the base codeword of the pattern.
- R5: The base codeword starts at all zeros and takes the step W' = {W[CHAIN_LEN-2:0], ~W[CHAIN_LEN-1]} after each pattern. It therefore returns to zero after 2*CHAIN_LEN patterns.
- R6: Take the word a chain receives in one pattern (its scan-in bits in shift order) and compare it with the word from the next pattern. The two words differ in exactly one bit when the seed bit of that chain is unchanged, and in exactly CHAIN_LEN-1 bits when that seed bit changed.
- R7: pi_o is never all zeros.
- R8: scan_o is all zeros during the capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_o | output | NUM_CHAINS | Scan-in bit for each chain |
| shift_en_o | output | 1 | High in shift cycles, low in the capture cycle |
| pi_o | output | LFSR_W | Seed applied to the primary inputs |
| done_o | output | 1 | One-cycle strobe in the capture cycle |

## Verification
The hardest state to reach from the ports is the wrap of the Johnson codeword back to all zeros. It only happens after 2*CHAIN_LEN complete patterns. Around that point the single-change property must still hold while the LFSR keeps flipping seed bits. The bench runs the generator continuously through more than one full Johnson period, with a reference model that advances the seed and the codeword in step with the design. At the pattern where the model's codeword is zero again, it checks that the scan bits collapse to the seed bits alone.

// File: rtl/msic_pkg.sv
package msic_pkg;
  typedef enum logic {
    PH_SHIFT = 1'b0,
    PH_CAPT  = 1'b1
  } phase_e;
endpackage

// File: rtl/msic_seed_lfsr.sv
module msic_seed_lfsr #(
  parameter int unsigned       W    = 8,
  parameter logic [W-1:0]      TAPS = 8'hB8,
  parameter logic [W-1:0]      SEED = 8'hA5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] seed_o
);
  logic [W-1:0] s_q;
  logic         fb;

  assign fb = ^(s_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    s_q <= SEED;
    else if (adv_i) s_q <= {s_q[W-2:0], fb};
  end

  assign seed_o = s_q;
endmodule

// File: rtl/msic_johnson.sv
module msic_johnson #(
  parameter int unsigned L = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         step_i,
  output logic [L-1:0] rot_o
);
  logic [L-1:0] base_q, rot_q, base_nxt;

  // ordinary Johnson step of the base codeword
  assign base_nxt = {base_q[L-2:0], ~base_q[L-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      rot_q  <= '0;
    end else if (step_i) begin
      base_q <= base_nxt;
      rot_q  <= base_nxt;
    end else if (shift_i) begin
      // circular rotation, new[j] = old[j-1]
      rot_q <= {rot_q[L-2:0], rot_q[L-1]};
    end
  end

  assign rot_o = rot_q;
endmodule

// File: rtl/msic_frame_ctrl.sv
module msic_frame_ctrl
  import msic_pkg::*;
#(
  parameter int unsigned L = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic shift_o,
  output logic capt_o
);
  localparam int unsigned CW = (L > 2) ? $clog2(L) : 1;

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_SHIFT;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_SHIFT: begin
          if (cnt_q == CW'(L - 1)) begin
            ph_q  <= PH_CAPT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CAPT: ph_q <= PH_SHIFT;
        default: ph_q <= PH_SHIFT;
      endcase
    end
  end

  assign shift_o = (ph_q == PH_SHIFT);
  assign capt_o  = (ph_q == PH_CAPT);
endmodule

// File: rtl/msic_tpg.sv
module msic_tpg #(
  parameter int unsigned          LFSR_W     = 8,
  parameter int unsigned          NUM_CHAINS = 4,
  parameter int unsigned          CHAIN_LEN  = 8,
  parameter logic [LFSR_W-1:0]    SEED       = 8'hA5,
  parameter logic [LFSR_W-1:0]    TAPS       = 8'hB8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [NUM_CHAINS-1:0] scan_o,
  output logic                  shift_en_o,
  output logic [LFSR_W-1:0]     pi_o,
  output logic                  done_o
);
  logic                 shift, capt;
  logic [LFSR_W-1:0]    seed;
  logic [CHAIN_LEN-1:0] rot;

  msic_frame_ctrl #(.L(CHAIN_LEN)) ctrl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_o(shift),
    .capt_o (capt)
  );

  msic_seed_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) lfsr_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (capt),
    .seed_o(seed)
  );

  msic_johnson #(.L(CHAIN_LEN)) john_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift),
    .step_i (capt),
    .rot_o  (rot)
  );

  for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_chain
    localparam int unsigned JI = i % CHAIN_LEN;
    localparam int unsigned SI = i % LFSR_W;
    assign scan_o[i] = shift & (rot[JI] ^ seed[SI]);
  end

  assign shift_en_o = shift;
  assign done_o     = capt;
  assign pi_o       = seed;
endmodule

// File: rtl/msic_tpg_chk.sv
module msic_tpg_chk #(
  parameter int unsigned LFSR_W     = 8,
  parameter int unsigned NUM_CHAINS = 4,
  parameter int unsigned CHAIN_LEN  = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_CHAINS-1:0] scan_o,
  input logic                  shift_en_o,
  input logic [LFSR_W-1:0]     pi_o,
  input logic                  done_o
);
  localparam int unsigned KW = $clog2(CHAIN_LEN + 2);
  logic [KW-1:0] nshift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         nshift_q <= '0;
    else if (done_o)     nshift_q <= '0;
    else if (shift_en_o) nshift_q <= nshift_q + 1'b1;
  end

  assert_frame_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (nshift_q == KW'(CHAIN_LEN)));
  assert_shift_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |-> (nshift_q < KW'(CHAIN_LEN)));
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && shift_en_o));
  assert_seed_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(shift_en_o) |-> $stable(pi_o));
  assert_seed_adv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (pi_o != $past(pi_o)));
  assert_pi_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pi_o != '0);
  assert_capt_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (scan_o == '0));
endmodule

bind msic_tpg msic_tpg_chk #(
  .LFSR_W    (LFSR_W),
  .NUM_CHAINS(NUM_CHAINS),
  .CHAIN_LEN (CHAIN_LEN)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scan_o    (scan_o),
  .shift_en_o(shift_en_o),
  .pi_o      (pi_o),
  .done_o    (done_o)
);

// File: tb/msic_tpg_tb_top.sv
module msic_tpg_tb_top;
  localparam int unsigned   LW   = 8;
  localparam int unsigned   NC   = 4;
  localparam int unsigned   CL   = 8;
  localparam logic [LW-1:0] SEED = 8'hA5;
  localparam logic [LW-1:0] TAPS = 8'hB8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] scan;
  logic          shift_en;
  logic [LW-1:0] pi;
  logic          done;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  msic_tpg #(.LFSR_W(LW), .NUM_CHAINS(NC), .CHAIN_LEN(CL), .SEED(SEED), .TAPS(TAPS)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scan_o    (scan),
    .shift_en_o(shift_en),
    .pi_o      (pi),
    .done_o    (done)
  );

  // reference model state
  logic [LW-1:0] m_seed, p_seed;
  logic [CL-1:0] m_w;
  logic [CL-1:0] cur_w [NC];
  logic [CL-1:0] prv_w [NC];
  bit            have_prv;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [NC-1:0] exp_scan(input int k);
    logic [NC-1:0] v;
    for (int i = 0; i < NC; i++)
      v[i] = m_w[((i % CL) - k + CL) % CL] ^ m_seed[i % LW];
    return v;
  endfunction

  task automatic check_reset();
    logic [NC-1:0] e;
    for (int i = 0; i < NC; i++) e[i] = SEED[i % LW];
    chk(shift_en === 1'b1, "R1", "shift_en", int'(shift_en), 1);
    chk(done === 1'b0, "R1", "done", int'(done), 0);
    chk(pi === SEED, "R1", "pi", int'(pi), int'(SEED));
    chk(scan === e, "R1", "scan", int'(scan), int'(e));
  endtask

  task automatic run_patterns(input int n);
    for (int p = 0; p < n; p++) begin
      for (int k = 0; k < CL; k++) begin
        logic [NC-1:0] e;
        e = exp_scan(k);
        chk(shift_en === 1'b1, "R3", "shift_en in shift", int'(shift_en), 1);
        chk(done === 1'b0, "R3", "done in shift", int'(done), 0);
        chk(pi === m_seed, "R2", "pi held", int'(pi), int'(m_seed));
        chk(scan === e, "R4", "scan bits", int'(scan), int'(e));
        for (int i = 0; i < NC; i++) cur_w[i][k] = scan[i];
        @(negedge clk);
      end
      chk(shift_en === 1'b0, "R3", "shift_en in capture", int'(shift_en), 0);
      chk(done === 1'b1, "R3", "done in capture", int'(done), 1);
      chk(scan === '0, "R8", "scan in capture", int'(scan), 0);
      chk(pi === m_seed, "R2", "pi in capture", int'(pi), int'(m_seed));
      chk(pi !== '0, "R7", "pi nonzero", int'(pi), 1);
      if (have_prv) begin
        for (int i = 0; i < NC; i++) begin
          int d;
          int ed;
          d  = $countones(cur_w[i] ^ prv_w[i]);
          ed = (m_seed[i % LW] == p_seed[i % LW]) ? 1 : CL - 1;
          chk(d == ed, "R6", "chain word distance", d, ed);
        end
      end
      for (int i = 0; i < NC; i++) prv_w[i] = cur_w[i];
      have_prv = 1'b1;
      p_seed = m_seed;
      m_seed = {m_seed[LW-2:0], ^(m_seed & TAPS)};
      m_w    = {m_w[CL-2:0], ~m_w[CL-1]};
      @(negedge clk);
    end
  endtask

  task automatic check_wrap();
    logic [NC-1:0] e;
    for (int i = 0; i < NC; i++) e[i] = m_seed[i % LW];
    chk(m_w == '0, "R5", "model codeword wrapped", int'(m_w), 0);
    chk(scan === e, "R5", "scan at wrap", int'(scan), int'(e));
    chk(pi === m_seed, "R2", "seed after 2L patterns", int'(pi), int'(m_seed));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_seed   = SEED;
    p_seed   = SEED;
    m_w      = '0;
    have_prv = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_reset();
    run_patterns(2 * CL);
    check_wrap();
    run_patterns(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule